// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the transfer datapath of a single DMA channel. Software loads it through a small write port with a starting address, a transfer count, a page value and a mode. The count is written as the number of transfers minus one. After the channel is unmasked, each transfer strobe from the arbiter is accepted. The block drives the physical memory address of that transfer, then advances its address counter and steps its count down.

The 16-bit address counter never carries into the page. Transfers therefore wrap inside a 64 KiB window on byte channels and inside a 128 KiB window on word channels. A word channel shifts the counter left by one bit and ignores bit 0 of the page. When the count runs out, the block pulses terminal count and latches a status flag. With autoinit set, it reloads the address and count from their base values. Without autoinit, it masks itself.

Top module: `dma_xfer_engine`

## Requirements
- R1: In byte mode (mode bit 2 = 0), `mem_addr` equals page * 65536 + current address.
- R2: In word mode (mode bit 2 = 1), `mem_addr` equals (page with bit 0 cleared) * 65536 + current address * 2, so A0 is always 0.
- R3: Each accepted strobe that does not reload advances the current address by one, modulo 65536. The address never carries into the page.
- R4: Each accepted strobe decrements the current count, modulo 65536. `tc_pulse` is high during an accepted strobe whose count is 0x0000, and that count then reads 0xFFFF. A loaded value N gives N+1 transfers.
- R5: With autoinit (mode bit 1) set, the terminal-count strobe reloads the current address and count from the last values written to them. The channel stays unmasked.
- R6: With autoinit clear, the terminal-count strobe sets the mask.
- R7: While masked, strobes are ignored: the address and count hold and `tc_pulse` stays low.
- R8: `tc_status` goes high the cycle after a terminal-count strobe. A `status_rd` clears it, but a terminal count in the same cycle wins.
- R9: Writes use the `wr_sel` codes 0 = address, 1 = count, 2 = page, 3 = mode. Mode bit 0 is the direction and appears on `mem_wr`. An address or count write loads both the base and the current value, and it wins over a strobe in the same cycle.
- R10: After reset, the channel is masked, all registers are zero, and `tc_status` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 count, 2 page, 3 mode |
| wr_data | input | CTR_W | Write data |
| mask_set | input | 1 | Mask the channel |
| mask_clr | input | 1 | Unmask the channel (loses to a set) |
| status_rd | input | 1 | Status read, clears `tc_status` |
| xfer_stb | input | 1 | Granted transfer strobe |
| mem_addr | output | PAGE_W+CTR_W | Physical address of the current transfer |
| mem_wr | output | 1 | Direction: 1 = write to memory |
| tc_pulse | output | 1 | Terminal count during this strobe |
| tc_status | output | 1 | Latched terminal-count flag |
| masked | output | 1 | Channel mask state |
| cur_addr | output | CTR_W | Current address counter read-back |
| cur_count | output | CTR_W | Current count read-back |

## Verification
Assertions check on every cycle the single-step movement of both counters. They also check that the counters hold while no strobe is accepted, and that a reload returns the base value. Beyond that, they check the page bits across a strobe, A0 in word mode, and the mask and status flags after a terminal count. Only the bench scenarios show the rest. Those are the wrap from 0xFFFF to 0x0000 under a fixed page, the exact number of transfers for a loaded count, the set-wins case of a status read that meets a terminal count, and a write that lands in the same cycle as a strobe.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_PAGE  = 2'd2,
    SEL_MODE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic word;       // bit 2
    logic auto_init;  // bit 1
    logic to_mem;     // bit 0
  } mode_t;
endpackage

// File: rtl/dma_reload_ctr.sv
module dma_reload_ctr #(
  parameter int W        = 16,
  parameter bit COUNT_UP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         reload,
  output logic [W-1:0] q,
  output logic [W-1:0] base_q
);
  localparam logic [W-1:0] STEP = COUNT_UP ? W'(1) : {W{1'b1}};

  logic [W-1:0] stepped;

  generate
    if (COUNT_UP) begin : g_up
      always_comb stepped = q + W'(1);
    end else begin : g_down
      always_comb stepped = q - W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      base_q <= '0;
    end else if (load) begin
      q      <= load_val;
      base_q <= load_val;
    end else if (step) begin
      q <= reload ? base_q : stepped;
    end
  end

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload && !load) |=> (q == W'($past(q) + STEP)));  // R3
  AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && reload && !load) |=> (q == $past(base_q)));  // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(q));  // R7
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_page,
  input  logic              wr_mode,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic              tc,
  input  logic              status_rd,
  input  logic              mask_set,
  input  logic              mask_clr,
  output logic [PAGE_W-1:0] page,
  output mode_t             mode,
  output logic              masked,
  output logic              tc_status
);
  logic self_mask;
  assign self_mask = tc && !mode.auto_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page      <= '0;
      mode      <= '0;
      masked    <= 1'b1;
      tc_status <= 1'b0;
    end else begin
      if (wr_page) page <= wr_data;
      if (wr_mode) mode <= mode_t'(wr_data[2:0]);
      if (mask_set || self_mask) masked <= 1'b1;
      else if (mask_clr)         masked <= 1'b0;
      if (tc)             tc_status <= 1'b1;
      else if (status_rd) tc_status <= 1'b0;
    end
  end

  AST_TC_SELF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    self_mask |=> masked);  // R6
  AST_TC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> tc_status);  // R8
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !tc) |=> !tc_status);  // R8
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int CTR_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [CTR_W-1:0]        wr_data,
  input  logic                    mask_set,
  input  logic                    mask_clr,
  input  logic                    status_rd,
  input  logic                    xfer_stb,
  output logic [PAGE_W+CTR_W-1:0] mem_addr,
  output logic                    mem_wr,
  output logic                    tc_pulse,
  output logic                    tc_status,
  output logic                    masked,
  output logic [CTR_W-1:0]        cur_addr,
  output logic [CTR_W-1:0]        cur_count
);
  localparam int PHYS_W = PAGE_W + CTR_W;

  function automatic logic [PHYS_W-1:0] form_phys(
    input logic [PAGE_W-1:0] pg, input logic [CTR_W-1:0] ctr, input logic word);
    if (word) return {pg[PAGE_W-1:1], ctr, 1'b0};
    return {pg, ctr};
  endfunction

  logic              xfer_go, count_empty, do_reload;
  logic              ld_addr, ld_count, ld_page, ld_mode;
  logic [PAGE_W-1:0] page;
  mode_t             mode;
  logic [CTR_W-1:0]  base_addr_unused, base_count_unused;

  assign ld_addr     = wr_en && (wr_sel == SEL_ADDR);
  assign ld_count    = wr_en && (wr_sel == SEL_COUNT);
  assign ld_page     = wr_en && (wr_sel == SEL_PAGE);
  assign ld_mode     = wr_en && (wr_sel == SEL_MODE);
  assign xfer_go     = xfer_stb && !masked;
  assign count_empty = (cur_count == '0);
  assign tc_pulse    = xfer_go && count_empty;
  assign do_reload   = tc_pulse && mode.auto_init;
  assign mem_addr    = form_phys(page, cur_addr, mode.word);
  assign mem_wr      = mode.to_mem;

  dma_reload_ctr #(.W(CTR_W), .COUNT_UP(1'b1)) u_addr_ctr (
    .clk(clk), .rst_n(rst_n), .load(ld_addr), .load_val(wr_data),
    .step(xfer_go), .reload(do_reload), .q(cur_addr), .base_q(base_addr_unused));

  dma_reload_ctr #(.W(CTR_W), .COUNT_UP(1'b0)) u_count_ctr (
    .clk(clk), .rst_n(rst_n), .load(ld_count), .load_val(wr_data),
    .step(xfer_go), .reload(do_reload), .q(cur_count), .base_q(base_count_unused));

  dma_chan_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_page(ld_page), .wr_mode(ld_mode),
    .wr_data(wr_data[PAGE_W-1:0]), .tc(tc_pulse), .status_rd(status_rd),
    .mask_set(mask_set), .mask_clr(mask_clr), .page(page), .mode(mode),
    .masked(masked), .tc_status(tc_status));

  AST_NO_PAGE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !wr_en) |=> $stable(mem_addr[PHYS_W-1:CTR_W+1]));  // R3
  AST_WORD_A0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode.word |-> !mem_addr[0]);  // R2
  AST_MASKED_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> !tc_pulse);  // R7
  AST_TC_WRAPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !mode.auto_init && !ld_count) |=> (cur_count == '1));  // R4
endmodule

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, mask_set = 0, mask_clr = 0, status_rd = 0, xfer_stb = 0;
  logic [1:0]  wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic [23:0] mem_addr;
  logic        mem_wr, tc_pulse, tc_status, masked;
  logic [15:0] cur_addr, cur_count;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_xfer_engine u_dma_xfer_engine (.*);

  // behavioural reference
  int m_base_a, m_a, m_base_c, m_c, m_page, m_mode;
  bit m_mask, m_tcs;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base_a = 0; m_a = 0; m_base_c = 0; m_c = 0; m_page = 0; m_mode = 0;
      m_mask = 1; m_tcs = 0;
    end else begin
      bit go, tc, aut;
      go  = xfer_stb && !m_mask;
      tc  = go && (m_c == 0);
      aut = (m_mode & 2) != 0;
      if (wr_en && wr_sel == 0) begin m_base_a = wr_data; m_a = wr_data; end
      else if (go) m_a = (tc && aut) ? m_base_a : (m_a + 1) % 65536;
      if (wr_en && wr_sel == 1) begin m_base_c = wr_data; m_c = wr_data; end
      else if (go) m_c = (tc && aut) ? m_base_c : (m_c + 65535) % 65536;
      if (wr_en && wr_sel == 2) m_page = wr_data & 255;
      if (wr_en && wr_sel == 3) m_mode = wr_data & 7;
      if (mask_set || (tc && !aut)) m_mask = 1;
      else if (mask_clr) m_mask = 0;
      if (tc) m_tcs = 1; else if (status_rd) m_tcs = 0;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    int exp_addr;
    if (m_mode & 4) exp_addr = (m_page / 2) * 131072 + m_a * 2;
    else            exp_addr = m_page * 65536 + m_a;
    chk((m_mode & 4) ? "R2 mem_addr" : "R1 mem_addr", int'(mem_addr), exp_addr);
    chk("R3 cur_addr", int'(cur_addr), m_a);
    chk("R4 cur_count", int'(cur_count), m_c);
    chk("R4 tc_pulse", int'(tc_pulse), int'(xfer_stb && !m_mask && m_c == 0));
    chk("R6 masked", int'(masked), int'(m_mask));
    chk("R8 tc_status", int'(tc_status), int'(m_tcs));
    chk("R9 mem_wr", int'(mem_wr), m_mode & 1);
  end

  task automatic drive(input bit we, input int sel, input int d, input bit stb,
                       input bit ms = 0, input bit mc = 0, input bit rd = 0);
    @(posedge clk); #1;
    wr_en = we; wr_sel = 2'(sel); wr_data = 16'(d); xfer_stb = stb;
    mask_set = ms; mask_clr = mc; status_rd = rd;
  endtask
  task automatic idle(); drive(0, 0, 0, 0); endtask
  task automatic settle(); idle(); @(negedge clk); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; done = 1;
      $display("FAIL watchdog expired (all R) act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R10 reset masked", int'(masked), 1);
    chk("R10 reset count", int'(cur_count), 0);
    chk("R10 reset status", int'(tc_status), 0);
    // R7: strobes while masked
    drive(0, 0, 0, 1); drive(0, 0, 0, 1); settle();
    chk("R7 masked addr hold", int'(cur_addr), 0);
    chk("R7 masked count hold", int'(cur_count), 0);
    // byte channel, wrap inside window, no autoinit
    drive(1, 2, 'h12, 0); drive(1, 0, 'hFFFE, 0); drive(1, 1, 2, 0);
    drive(1, 3, 'b001, 0); drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 1); drive(0, 0, 0, 1); drive(0, 0, 0, 1); settle();
    chk("R3 wrap no carry", int'(cur_addr), 1);
    chk("R1 page kept", int'(mem_addr), 'h120001);
    chk("R4 count wrapped", int'(cur_count), 'hFFFF);
    chk("R6 self masked", int'(masked), 1);
    chk("R8 status set", int'(tc_status), 1);
    drive(0, 0, 0, 1); settle();
    chk("R7 ignored after tc", int'(cur_addr), 1);
    drive(0, 0, 0, 0, 0, 0, 1); settle();
    chk("R8 read clears", int'(tc_status), 0);
    // word channel with autoinit
    drive(1, 2, 'h35, 0); drive(1, 0, 'h1234, 0); drive(1, 1, 1, 0);
    drive(1, 3, 'b110, 0); drive(0, 0, 0, 0, 0, 1); settle();
    chk("R2 word address", int'(mem_addr), 'h342468);
    drive(0, 0, 0, 1); drive(0, 0, 0, 1); settle();
    chk("R5 addr reloaded", int'(cur_addr), 'h1234);
    chk("R5 count reloaded", int'(cur_count), 1);
    chk("R5 still unmasked", int'(masked), 0);
    drive(0, 0, 0, 0, 0, 0, 1); drive(0, 0, 0, 1); drive(0, 0, 0, 1, 0, 0, 1); settle();
    chk("R8 tc beats read", int'(tc_status), 1);
    // R9: write beats strobe
    drive(1, 1, 5, 1); settle();
    chk("R9 count write wins", int'(cur_count), 5);
    chk("R9 addr stepped", int'(cur_addr), 'h1235);
    // R7: explicit mask
    drive(0, 0, 0, 0, 1); drive(0, 0, 0, 1); drive(0, 0, 0, 1); settle();
    chk("R7 mask_set hold", int'(cur_count), 5);
    repeat (3) idle();
    @(negedge clk); done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule